// File: doc/BRIEF.md
# Nonvolatile Save Trigger Controller

This block sits between a byte-wide volatile configuration register file and a nonvolatile backing store. After reset it fetches every byte from the store and hands each one to the register file, so the device comes up with the stored configuration. Afterwards it watches a single trigger bit inside the register file. When that bit goes from 0 to 1, the block copies the whole register file into the store one byte at a time. During the copy it raises a busy status and tells the bus slave to refuse writes.

Two configuration bits matter to the block only in their stored form. The first is a permanent lock, which stops any further save. The second selects the function of the shared serial pins, and the block exports it to the pin logic. Each one changes only when its byte is written to the store or read back from it at boot. Changing the live register has no effect on either of them. The store is reached through a simple word-serial port. Every byte slot lasts a fixed, parameterised number of clocks, and the port has no acknowledge.

Top module: `nvs_save_top`

## Requirements
- R1: After reset the block reads store bytes 0 to NUM_BYTES-1 in ascending order, one read strobe per slot. It presents each byte on the load port in the strobe cycle. `writeBlock` stays high for exactly NUM_BYTES*SLOT_CLKS cycles after reset is released, and `saveBusy` stays low during this load.
- R2: A save starts only when the trigger bit (byte 6, bit 0 of `liveRegs`) changes from 0 to 1 while the block is idle and unlocked. `saveBusy` rises one clock after the first cycle in which the bit is seen high.
- R3: A trigger bit that stays high starts no further save. The bit has to return to 0 before a new request can be made.
- R4: `saveBusy` stays high for exactly NUM_BYTES*SLOT_CLKS cycles per save.
- R5: `writeBlock` is high whenever `saveBusy` is high. A bus write attempted during a save leaves the register file unchanged.
- R6: A save writes bytes 0 to NUM_BYTES-1 in ascending order, with one write strobe in the last cycle of each slot. Each `memWdata` equals the live register byte at `memAddr`.
- R7: A trigger rising edge that arrives while a save is running is dropped and not queued, so exactly one save takes place.
- R8: The lock is byte 1, bit 5. Once a committed 1 is in place, whether from a save or from the boot load, `lockActive` is 1 and trigger edges start no save. Live register writes are still accepted.
- R9: `pinModeActive` follows byte 2, bit 6 as committed to the store or loaded from it.
- R10: Setting the lock or pin-mode bit in the live registers alone does not change `lockActive` or `pinModeActive`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| liveRegs | input | NUM_BYTES*8 | Volatile register file contents, byte i at bits [8i+7:8i] |
| saveBusy | output | 1 | Save in progress (status bit) |
| writeBlock | output | 1 | Bus-write inhibit to the bus slave (boot load or save) |
| lockActive | output | 1 | Committed permanent lock |
| pinModeActive | output | 1 | Committed serial-pin mode select |
| memAddr | output | ADDR_W | Store byte address |
| memWe | output | 1 | Store write strobe |
| memRd | output | 1 | Store read strobe |
| memWdata | output | 8 | Store write data |
| memRdata | input | 8 | Store read data |
| loadStb | output | 1 | Register file load strobe |
| loadAddr | output | ADDR_W | Register file load address |
| loadData | output | 8 | Register file load data |

## Verification
The assertions check the following on every cycle. Busy always implies write inhibit. A save begins only after a trigger transition and never while the lock is committed. The committed flags change only on a store strobe. The store address holds still between strobes, write strobes never fall on back-to-back cycles, and the boot load issues no write. Only the bench scenarios can show the exact slot counts of the load and the save, the ascending byte order, the store contents after a copy, the dropped mid-save edge, and the lock surviving a second reset through the boot load.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
  typedef enum logic [1:0] {
    ST_BOOT = 2'd0,
    ST_IDLE = 2'd1,
    ST_SAVE = 2'd2
  } nvsState_e;

  typedef struct packed {
    logic rdStb;
    logic wrStb;
  } nvsStrobes_t;
endpackage

// File: rtl/nvs_ctrl.sv
module nvs_ctrl
  import nvs_pkg::*;
#(
  parameter int NUM_BYTES = 32,
  parameter int SLOT_CLKS = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          trigLevel,
  input  logic                          lockActive,
  output nvsStrobes_t                   stb,
  output logic [$clog2(NUM_BYTES)-1:0]  byteIdx,
  output logic                          saveBusy,
  output logic                          writeBlock
);
  localparam int ADDR_W = $clog2(NUM_BYTES);
  localparam int CNT_W  = (SLOT_CLKS > 1) ? $clog2(SLOT_CLKS) : 1;
  localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(NUM_BYTES - 1);
  localparam logic [CNT_W-1:0]  LAST_CNT = CNT_W'(SLOT_CLKS - 1);

  nvsState_e state;
  logic [CNT_W-1:0] slotCnt;
  logic trigPrev;
  logic trigEdge;
  logic slotEnd;
  logic lastByte;

  assign trigEdge = trigLevel & ~trigPrev;
  assign slotEnd  = (slotCnt == LAST_CNT);
  assign lastByte = (byteIdx == LAST_IDX);

  always_ff @(posedge clk) begin
    if (!rstN) trigPrev <= 1'b0;
    else       trigPrev <= trigLevel;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_BOOT;
      slotCnt <= '0;
      byteIdx <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          slotCnt <= '0;
          byteIdx <= '0;
          if (trigEdge && !lockActive) state <= ST_SAVE;
        end
        ST_BOOT, ST_SAVE: begin
          if (slotEnd) begin
            slotCnt <= '0;
            if (lastByte) begin
              byteIdx <= '0;
              state   <= ST_IDLE;
            end else begin
              byteIdx <= byteIdx + 1'b1;
            end
          end else begin
            slotCnt <= slotCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    stb.rdStb  = (state == ST_BOOT) && slotEnd;
    stb.wrStb  = (state == ST_SAVE) && slotEnd;
    saveBusy   = (state == ST_SAVE);
    writeBlock = (state != ST_IDLE);
  end

  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rstN) saveBusy |-> writeBlock); // R5
  AST_EDGE_START: assert property (@(posedge clk) disable iff (!rstN)
    $rose(saveBusy) |-> ($past(trigLevel) && !$past(trigLevel, 2))); // R2
  AST_NO_LOCKED_START: assert property (@(posedge clk) disable iff (!rstN)
    $rose(saveBusy) |-> !$past(lockActive)); // R8
endmodule

// File: rtl/nvs_datapath.sv
module nvs_datapath
  import nvs_pkg::*;
#(
  parameter int NUM_BYTES   = 32,
  parameter int TRIG_OFFSET = 6,
  parameter int TRIG_BIT    = 0,
  parameter int LOCK_OFFSET = 1,
  parameter int LOCK_BIT    = 5,
  parameter int PIN_OFFSET  = 2,
  parameter int PIN_BIT     = 6
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_BYTES*8-1:0]        liveRegs,
  input  nvsStrobes_t                   stb,
  input  logic [$clog2(NUM_BYTES)-1:0]  byteIdx,
  input  logic                          saveBusy,
  input  logic                          writeBlock,
  input  logic [7:0]                    memRdata,
  output logic                          trigLevel,
  output logic                          lockActive,
  output logic                          pinModeActive,
  output logic [$clog2(NUM_BYTES)-1:0]  memAddr,
  output logic                          memWe,
  output logic                          memRd,
  output logic [7:0]                    memWdata,
  output logic                          loadStb,
  output logic [$clog2(NUM_BYTES)-1:0]  loadAddr,
  output logic [7:0]                    loadData
);
  localparam int ADDR_W = $clog2(NUM_BYTES);
  localparam int NUM_FLAGS = 2;
  localparam int FLAG_OFS [NUM_FLAGS] = '{LOCK_OFFSET, PIN_OFFSET};
  localparam int FLAG_BIT [NUM_FLAGS] = '{LOCK_BIT, PIN_BIT};

  logic [7:0] commitByte;
  logic       commitEn;
  logic [NUM_FLAGS-1:0] flagQ;

  assign trigLevel = liveRegs[TRIG_OFFSET*8 + TRIG_BIT];
  assign memAddr   = byteIdx;
  assign memWe     = stb.wrStb;
  assign memRd     = stb.rdStb;
  assign memWdata  = liveRegs[byteIdx*8 +: 8];
  assign loadStb   = stb.rdStb;
  assign loadAddr  = byteIdx;
  assign loadData  = memRdata;

  assign commitEn   = stb.wrStb | stb.rdStb;
  assign commitByte = stb.wrStb ? memWdata : memRdata;

  for (genvar f = 0; f < NUM_FLAGS; f++) begin : gFlag
    always_ff @(posedge clk) begin
      if (!rstN) flagQ[f] <= 1'b0;
      else if (commitEn && (byteIdx == ADDR_W'(FLAG_OFS[f])))
        flagQ[f] <= commitByte[FLAG_BIT[f]];
    end
  end

  assign lockActive    = flagQ[0];
  assign pinModeActive = flagQ[1];

  AST_LOCK_ON_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(lockActive) |-> $past(memWe || memRd)); // R8
  AST_PIN_ON_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(pinModeActive) |-> $past(memWe || memRd)); // R9
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !$past(memWe || memRd) |-> $stable(memAddr)); // R6
  AST_WR_SPACED: assert property (@(posedge clk) disable iff (!rstN) memWe |=> !memWe); // R4
  AST_BOOT_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (writeBlock && !saveBusy) |-> !memWe); // R1
endmodule

// File: rtl/nvs_save_top.sv
module nvs_save_top
  import nvs_pkg::*;
#(
  parameter int NUM_BYTES = 32,
  parameter int SLOT_CLKS = 4,
  localparam int ADDR_W   = $clog2(NUM_BYTES)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_BYTES*8-1:0] liveRegs,
  output logic                   saveBusy,
  output logic                   writeBlock,
  output logic                   lockActive,
  output logic                   pinModeActive,
  output logic [ADDR_W-1:0]      memAddr,
  output logic                   memWe,
  output logic                   memRd,
  output logic [7:0]             memWdata,
  input  logic [7:0]             memRdata,
  output logic                   loadStb,
  output logic [ADDR_W-1:0]      loadAddr,
  output logic [7:0]             loadData
);
  nvsStrobes_t stb;
  logic [ADDR_W-1:0] byteIdx;
  logic trigLevel;

  nvs_ctrl #(.NUM_BYTES(NUM_BYTES), .SLOT_CLKS(SLOT_CLKS)) uCtrl (
    .clk(clk), .rstN(rstN), .trigLevel(trigLevel), .lockActive(lockActive),
    .stb(stb), .byteIdx(byteIdx), .saveBusy(saveBusy), .writeBlock(writeBlock)
  );

  nvs_datapath #(.NUM_BYTES(NUM_BYTES)) uData (
    .clk(clk), .rstN(rstN), .liveRegs(liveRegs), .stb(stb), .byteIdx(byteIdx),
    .saveBusy(saveBusy), .writeBlock(writeBlock), .memRdata(memRdata),
    .trigLevel(trigLevel), .lockActive(lockActive), .pinModeActive(pinModeActive),
    .memAddr(memAddr), .memWe(memWe), .memRd(memRd), .memWdata(memWdata),
    .loadStb(loadStb), .loadAddr(loadAddr), .loadData(loadData)
  );
endmodule

// File: tb/tb_nvs_save_top.sv
module tb_nvs_save_top;
  localparam int N = 32;
  localparam int HS = 4;
  localparam int AW = $clog2(N);
  localparam int WINDOW = N * HS;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [N*8-1:0] liveRegs = '0;
  logic saveBusy, writeBlock, lockActive, pinModeActive, memWe, memRd, loadStb;
  logic [AW-1:0] memAddr, loadAddr;
  logic [7:0] memWdata, memRdata, loadData;
  logic [7:0] store [N];

  int checks = 0, fails = 0;
  int busyCnt = 0, blockCnt = 0, wrCount = 0, rdCount = 0;
  int wrLog [64];
  int rdLog [64];
  bit finished = 1'b0;

  always #10 clk = ~clk;

  nvs_save_top #(.NUM_BYTES(N), .SLOT_CLKS(HS)) dut (
    .clk(clk), .rstN(rstN), .liveRegs(liveRegs), .saveBusy(saveBusy),
    .writeBlock(writeBlock), .lockActive(lockActive), .pinModeActive(pinModeActive),
    .memAddr(memAddr), .memWe(memWe), .memRd(memRd), .memWdata(memWdata),
    .memRdata(memRdata), .loadStb(loadStb), .loadAddr(loadAddr), .loadData(loadData)
  );

  assign memRdata = store[memAddr];

  always @(posedge clk) begin
    if (rstN && memWe) begin
      store[memAddr] <= memWdata;
      if (wrCount < 64) wrLog[wrCount] = int'(memAddr);
      wrCount++;
    end
    if (rstN && loadStb) begin
      liveRegs[loadAddr*8 +: 8] <= loadData;
      if (rdCount < 64) rdLog[rdCount] = int'(loadAddr);
      rdCount++;
    end
  end

  always @(negedge clk) begin
    if (rstN && saveBusy) busyCnt++;
    if (rstN && writeBlock) blockCnt++;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clearCounts();
    busyCnt = 0; blockCnt = 0; wrCount = 0; rdCount = 0;
  endtask

  task automatic busWrite(input int idx, input logic [7:0] val, output bit accepted);
    @(negedge clk);
    accepted = !writeBlock;
    if (accepted) liveRegs[idx*8 +: 8] = val;
  endtask

  task automatic waitIdle();
    for (int k = 0; k < 1000; k++) begin
      @(negedge clk);
      if (!writeBlock) break;
    end
  endtask

  task automatic waitClk(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    checks++;
    $display("FAIL watchdog: actual 1 expected 0");
    summary();
  end

  initial begin
    bit acc;
    int bad;
    logic [7:0] old10;
    for (int i = 0; i < N; i++) store[i] = 8'((i * 37 + 11) & 8'hFF);
    store[1][5] = 1'b0;
    store[2][6] = 1'b1;
    store[6][0] = 1'b0;

    // reset and boot load
    waitClk(4);
    chk(saveBusy == 1'b0, "R1", "saveBusy in reset", int'(saveBusy), 0);
    clearCounts();
    @(negedge clk); rstN = 1'b1;
    waitIdle();
    chk(blockCnt == WINDOW, "R1", "boot inhibit cycles", blockCnt, WINDOW);
    chk(rdCount == N, "R1", "boot reads", rdCount, N);
    chk(busyCnt == 0, "R1", "busy during boot", busyCnt, 0);
    bad = 0;
    for (int i = 0; i < N; i++) begin
      if (rdLog[i] != i) bad++;
      if (liveRegs[i*8 +: 8] != store[i]) bad++;
    end
    chk(bad == 0, "R1", "boot order/content mismatches", bad, 0);
    chk(lockActive == 1'b0, "R8", "lock after clean boot", int'(lockActive), 0);
    chk(pinModeActive == 1'b1, "R9", "pin mode after boot", int'(pinModeActive), 1);

    // new configuration, trigger written last
    for (int i = 0; i < N; i++) begin
      logic [7:0] v;
      v = 8'((i * 53 + 7) & 8'hFF);
      if (i == 1) v[5] = 1'b0;
      if (i == 2) v[6] = 1'b0;
      if (i == 6) v[0] = 1'b0;
      busWrite(i, v, acc);
    end
    waitClk(3);
    chk(wrCount == 0, "R2", "writes without trigger", wrCount, 0);
    clearCounts();
    busWrite(6, liveRegs[6*8 +: 8] | 8'h01, acc);
    @(negedge clk);
    chk(saveBusy == 1'b1, "R2", "busy one clock after edge", int'(saveBusy), 1);
    chk(writeBlock == 1'b1, "R5", "inhibit during save", int'(writeBlock), 1);
    busWrite(20, 8'hA5, acc);
    chk(!acc && liveRegs[20*8 +: 8] != 8'hA5, "R5", "write accepted during save", int'(acc), 0);
    waitIdle();
    chk(busyCnt == WINDOW, "R4", "busy cycles", busyCnt, WINDOW);
    chk(wrCount == N, "R6", "store writes", wrCount, N);
    bad = 0;
    for (int i = 0; i < N; i++) begin
      if (wrLog[i] != i) bad++;
      if (store[i] != liveRegs[i*8 +: 8]) bad++;
    end
    chk(bad == 0, "R6", "order/content mismatches", bad, 0);
    chk(pinModeActive == 1'b0, "R9", "pin mode after save", int'(pinModeActive), 0);

    // held trigger
    clearCounts();
    waitClk(300);
    chk(wrCount == 0 && busyCnt == 0, "R3", "save with held trigger", wrCount + busyCnt, 0);

    // mid-save edge dropped
    busWrite(6, liveRegs[6*8 +: 8] & 8'hFE, acc);
    clearCounts();
    busWrite(6, liveRegs[6*8 +: 8] | 8'h01, acc);
    waitClk(20);
    liveRegs[6*8] = 1'b0;
    @(negedge clk);
    liveRegs[6*8] = 1'b1;
    waitIdle();
    waitClk(300);
    chk(wrCount == N, "R7", "writes after mid-save edge", wrCount, N);
    chk(busyCnt == WINDOW, "R7", "busy cycles after mid-save edge", busyCnt, WINDOW);

    // lock: live only, then committed
    busWrite(6, liveRegs[6*8 +: 8] & 8'hFE, acc);
    busWrite(1, liveRegs[1*8 +: 8] | 8'h20, acc);
    busWrite(2, liveRegs[2*8 +: 8] | 8'h40, acc);
    waitClk(3);
    chk(lockActive == 1'b0, "R10", "lock from live write", int'(lockActive), 0);
    chk(pinModeActive == 1'b0, "R10", "pin mode from live write", int'(pinModeActive), 0);
    clearCounts();
    busWrite(6, liveRegs[6*8 +: 8] | 8'h01, acc);
    waitClk(2);
    waitIdle();
    chk(wrCount == N, "R8", "save before lock commit", wrCount, N);
    chk(lockActive == 1'b1, "R8", "lock after commit", int'(lockActive), 1);
    chk(pinModeActive == 1'b1, "R9", "pin mode after commit", int'(pinModeActive), 1);
    busWrite(6, liveRegs[6*8 +: 8] & 8'hFE, acc);
    old10 = store[10];
    busWrite(10, ~old10, acc);
    chk(acc && liveRegs[10*8 +: 8] == ~old10, "R8", "live write while locked", int'(acc), 1);
    clearCounts();
    busWrite(6, liveRegs[6*8 +: 8] | 8'h01, acc);
    waitClk(300);
    chk(wrCount == 0 && busyCnt == 0, "R8", "save while locked", wrCount + busyCnt, 0);
    chk(store[10] == old10, "R8", "store byte 10 while locked", int'(store[10]), int'(old10));

    // second reset: lock restored from store
    @(negedge clk); rstN = 1'b0; liveRegs = '0;
    waitClk(3);
    clearCounts();
    @(negedge clk); rstN = 1'b1;
    waitIdle();
    chk(lockActive == 1'b1, "R8", "lock after reboot", int'(lockActive), 1);
    chk(blockCnt == WINDOW, "R1", "reboot inhibit cycles", blockCnt, WINDOW);
    bad = 0;
    for (int i = 0; i < N; i++) if (liveRegs[i*8 +: 8] != store[i]) bad++;
    chk(bad == 0, "R1", "reboot content mismatches", bad, 0);

    summary();
  end
endmodule